// File: doc/BRIEF.md
# Multi-Domain Power Sequencer

This block drives the power switches of eight independent power domains from a 32-bit memory-mapped register bus. Each domain has its own 4 KiB register window. The window holds a request register, a read-only state register and five timing registers. Software writes a target mode into the request register. The domain then raises its switch-enable outputs one stage at a time, waiting a programmed number of cycles between stages. After the last stage it waits a final settle period, and only then does the state register show the new mode.

Software detects completion by polling the state register until its mode field equals the requested one. Powering down drops the switch enables in reverse order. Mode codes other than ON and OFF are stored in the request register but do not start a sequence. A request written while a sequence is running is stored at once and is acted on when that sequence ends.

Top module: `pwr_domain_ctl`

## Requirements
- R1: Domain d owns addresses d*0x1000 to d*0x1000+0xFFF, where d = bus_addr[14:12]. An access in one window never changes the registers, enables or ready output of any other domain.
- R2: The request register at offset 0x000 stores all 32 written bits. A read in the cycle after a write returns the written value. Bits [3:0] are the requested mode: 0x8 is ON and 0x0 is OFF.
- R3: The state register at offset 0x008 reads 0x8 in bits [3:0] when the domain is ON and 0x0 when it is OFF, with all other bits zero. Writes to it have no effect.
- R4: The timing registers at 0x170, 0x174, 0xC00, 0xC04 and 0xC10 store and read back all 32 bits. Byte k of 0xC00 (bits 8k+7:8k) is the delay of stage k for k = 0..3. Bytes 0 and 1 of 0xC04 are the delays of stages 4 and 5. Bits [7:0] of 0xC10 are the settle delay.
- R5: When an OFF domain's request becomes 0x8 at clock edge W, switch stage 0 enables at edge W+1. Stage k+1 enables (delay of stage k)+1 edges after stage k, and enables are only ever added from stage 0 upward. Domain d's stage k is bit d*6+k of sw_en.
- R6: The state becomes ON, and pd_ready[d] rises, (settle delay)+1 edges after the edge at which the last stage's delay has run out. pd_ready is high exactly when the domain is ON and no sequence is running.
- R7: When an ON domain's request becomes 0x0 at edge W, pd_ready falls at W+1. Stage 5 releases at W+2, and each lower stage releases one edge after the stage above it. The state reads OFF from the same edge at which stage 0 releases.
- R8: A request with mode bits other than 0x0 or 0x8 is stored and read back, but it starts no sequence and leaves the state unchanged.
- R9: A request written during a sequence does not alter that sequence. The state changes only when a sequence completes. Once the sequence ends, the latest stored request is acted on.
- R10: Reset (synchronous, active high) clears every register to zero, so every domain starts OFF with all enables low. Reads of unmapped offsets return zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 15 | Byte address: domain in [14:12], offset in [11:0] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| sw_en | output | 48 | Switch enables, bit d*6+k = domain d stage k |
| pd_ready | output | 8 | Domain d is ON and idle |

## Verification
Some properties are checked on every cycle. The enables of each domain always form a run of ones from stage 0 upward, and they change by at most one stage per cycle. A ready domain has every stage enabled, and an idle OFF domain has none. The state changes only as a sequence completes, and a request readback always reflects the previous write. The exact stage-to-stage spacing, the settle delay, the reverse release timing, deferred requests and ignored mode codes depend on programmed values and write history. These only show up in the bench scenarios, which compare against a behavioural model on every clock.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

    localparam int WIN_BITS = 12;

    localparam logic [WIN_BITS-1:0] OFS_REQ    = 12'h000;
    localparam logic [WIN_BITS-1:0] OFS_STATE  = 12'h008;
    localparam logic [WIN_BITS-1:0] OFS_DEVDLY0 = 12'h170;
    localparam logic [WIN_BITS-1:0] OFS_DEVDLY1 = 12'h174;
    localparam logic [WIN_BITS-1:0] OFS_STGDLY0 = 12'hC00;
    localparam logic [WIN_BITS-1:0] OFS_STGDLY1 = 12'hC04;
    localparam logic [WIN_BITS-1:0] OFS_SETTLE = 12'hC10;

    localparam logic [3:0] MODE_OFF = 4'h0;
    localparam logic [3:0] MODE_ON  = 4'h8;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_RAMP,
        SEQ_SETTLE,
        SEQ_DROP
    } seq_state_t;

    typedef struct packed {
        logic [3:0]  req_mode;
        logic [31:0] stg_dly0;
        logic [31:0] stg_dly1;
        logic [7:0]  settle;
    } dom_cfg_t;

    function automatic logic [7:0] stage_delay(input dom_cfg_t c, input int k);
        logic [63:0] both;
        both = {c.stg_dly1, c.stg_dly0};
        return both[8*k +: 8];
    endfunction

    function automatic logic [31:0] state_word(input logic on);
        return {28'h0, on ? MODE_ON : MODE_OFF};
    endfunction

endpackage

// File: rtl/pdc_regs.sv
module pdc_regs
    import pdc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr,
    input  logic [WIN_BITS-1:0] ofs,
    input  logic [31:0]         wdata,
    input  logic                dom_on,
    output logic [31:0]         rdata,
    output dom_cfg_t            cfg
);

    logic [31:0] req_q, dev0_q, dev1_q, stg0_q, stg1_q, settle_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q    <= '0;
            dev0_q   <= '0;
            dev1_q   <= '0;
            stg0_q   <= '0;
            stg1_q   <= '0;
            settle_q <= '0;
        end else if (wr) begin
            case (ofs)
                OFS_REQ:     req_q    <= wdata;
                OFS_DEVDLY0: dev0_q   <= wdata;
                OFS_DEVDLY1: dev1_q   <= wdata;
                OFS_STGDLY0: stg0_q   <= wdata;
                OFS_STGDLY1: stg1_q   <= wdata;
                OFS_SETTLE:  settle_q <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (ofs)
            OFS_REQ:     rdata = req_q;
            OFS_STATE:   rdata = state_word(dom_on);
            OFS_DEVDLY0: rdata = dev0_q;
            OFS_DEVDLY1: rdata = dev1_q;
            OFS_STGDLY0: rdata = stg0_q;
            OFS_STGDLY1: rdata = stg1_q;
            OFS_SETTLE:  rdata = settle_q;
            default:     rdata = '0;
        endcase
    end

    always_comb begin
        cfg.req_mode = req_q[3:0];
        cfg.stg_dly0 = stg0_q;
        cfg.stg_dly1 = stg1_q;
        cfg.settle   = settle_q[7:0];
    end

    AST_REQ_READBACK: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && wr && ofs == OFS_REQ) |-> req_q == $past(wdata)); // R2

endmodule

// File: rtl/pdc_seq.sv
module pdc_seq
    import pdc_pkg::*;
#(
    parameter int NUM_STAGES = 6,
    localparam int IDX_W = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1,
    localparam int LAST  = NUM_STAGES - 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  dom_cfg_t              cfg,
    output logic [NUM_STAGES-1:0] sw_en,
    output logic                  dom_on,
    output logic                  ready
);

    seq_state_t       state;
    logic [IDX_W-1:0] idx;
    logic [7:0]       cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SEQ_IDLE;
            idx    <= '0;
            cnt    <= '0;
            sw_en  <= '0;
            dom_on <= 1'b0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (!dom_on && cfg.req_mode == MODE_ON) begin
                        state    <= SEQ_RAMP;
                        idx      <= '0;
                        sw_en[0] <= 1'b1;
                        cnt      <= stage_delay(cfg, 0);
                    end else if (dom_on && cfg.req_mode == MODE_OFF) begin
                        state <= SEQ_DROP;
                        idx   <= IDX_W'(LAST);
                    end
                end
                SEQ_RAMP: begin
                    if (cnt != 0) begin
                        cnt <= cnt - 8'd1;
                    end else if (int'(idx) == LAST) begin
                        state <= SEQ_SETTLE;
                        cnt   <= cfg.settle;
                    end else begin
                        idx                  <= idx + 1'b1;
                        sw_en[int'(idx) + 1] <= 1'b1;
                        cnt                  <= stage_delay(cfg, int'(idx) + 1);
                    end
                end
                SEQ_SETTLE: begin
                    if (cnt != 0) begin
                        cnt <= cnt - 8'd1;
                    end else begin
                        dom_on <= 1'b1;
                        state  <= SEQ_IDLE;
                    end
                end
                default: begin
                    sw_en[idx] <= 1'b0;
                    if (idx == '0) begin
                        dom_on <= 1'b0;
                        state  <= SEQ_IDLE;
                    end else begin
                        idx <= idx - 1'b1;
                    end
                end
            endcase
        end
    end

    assign ready = dom_on && (state == SEQ_IDLE);

    AST_THERMO_ENABLES: assert property (@(posedge clk) disable iff (rst)
        (sw_en & (sw_en + NUM_STAGES'(1))) == '0); // R5

    AST_ONE_STAGE_STEP: assert property (@(posedge clk) disable iff (rst)
        $countones(sw_en ^ $past(sw_en)) <= 1); // R7

    AST_READY_FULL_ON: assert property (@(posedge clk) disable iff (rst)
        ready |-> (&sw_en)); // R6

    AST_IDLE_OFF_DARK: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_IDLE && !dom_on) |-> sw_en == '0); // R10

    AST_STATE_AT_END: assert property (@(posedge clk) disable iff (rst)
        (dom_on != $past(dom_on)) |-> $past(state) != SEQ_IDLE); // R9

endmodule

// File: rtl/pwr_domain_ctl.sv
module pwr_domain_ctl
    import pdc_pkg::*;
#(
    parameter int NUM_DOMAINS = 8,
    parameter int NUM_STAGES  = 6,
    localparam int DOM_W  = (NUM_DOMAINS > 1) ? $clog2(NUM_DOMAINS) : 1,
    localparam int ADDR_W = WIN_BITS + DOM_W,
    localparam int EN_W   = NUM_DOMAINS * NUM_STAGES
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bus_wr,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [31:0]            bus_wdata,
    output logic [31:0]            bus_rdata,
    output logic [EN_W-1:0]        sw_en,
    output logic [NUM_DOMAINS-1:0] pd_ready
);

    logic [DOM_W-1:0]    sel_dom;
    logic [WIN_BITS-1:0] sel_ofs;
    logic [31:0]         dom_rdata [NUM_DOMAINS];

    assign sel_dom = bus_addr[ADDR_W-1:WIN_BITS];
    assign sel_ofs = bus_addr[WIN_BITS-1:0];

    for (genvar d = 0; d < NUM_DOMAINS; d++) begin : g_dom
        dom_cfg_t cfg;
        logic     dom_on;

        pdc_regs u_regs (
            .clk    (clk),
            .rst    (rst),
            .wr     (bus_wr && int'(sel_dom) == d),
            .ofs    (sel_ofs),
            .wdata  (bus_wdata),
            .dom_on (dom_on),
            .rdata  (dom_rdata[d]),
            .cfg    (cfg)
        );

        pdc_seq #(.NUM_STAGES(NUM_STAGES)) u_seq (
            .clk    (clk),
            .rst    (rst),
            .cfg    (cfg),
            .sw_en  (sw_en[d*NUM_STAGES +: NUM_STAGES]),
            .dom_on (dom_on),
            .ready  (pd_ready[d])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int d = 0; d < NUM_DOMAINS; d++) begin
            if (int'(sel_dom) == d) bus_rdata = dom_rdata[d];
        end
    end

endmodule

// File: tb/pwr_domain_ctl_tb.sv
module pwr_domain_ctl_tb_top;

    localparam int ND = 8;
    localparam int NS = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [14:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [47:0] sw_en;
    logic [7:0]  pd_ready;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 1'b0;

    pwr_domain_ctl dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sw_en(sw_en), .pd_ready(pd_ready)
    );

    always #5 clk = ~clk;

    // behavioural reference model
    logic [31:0] m_req [ND];
    logic [31:0] m_dv0 [ND];
    logic [31:0] m_dv1 [ND];
    logic [31:0] m_sd0 [ND];
    logic [31:0] m_sd1 [ND];
    logic [31:0] m_stl [ND];
    bit          m_on  [ND];
    int          m_ph  [ND];   // 0 idle, 1 rising, 2 falling
    int          m_t   [ND];
    int          m_end [ND];

    function automatic int stage_dly(int d, int k);
        if (k < 4) return int'(m_sd0[d][8*k +: 8]);
        return int'(m_sd1[d][8*(k-4) +: 8]);
    endfunction

    function automatic int rise_at(int d, int k);
        int r = 0;
        for (int j = 0; j < k; j++) r += stage_dly(d, j) + 1;
        return r;
    endfunction

    function automatic logic [NS-1:0] exp_en(int d);
        logic [NS-1:0] v = '0;
        for (int k = 0; k < NS; k++) begin
            if (m_ph[d] == 1) v[k] = (m_t[d] >= rise_at(d, k));
            else if (m_ph[d] == 2) v[k] = (k <= NS - 1 - m_t[d]);
            else v[k] = m_on[d];
        end
        return v;
    endfunction

    function automatic logic [31:0] model_read(logic [14:0] a);
        int d = int'(a[14:12]);
        case (a[11:0])
            12'h000: return m_req[d];
            12'h008: return m_on[d] ? 32'h8 : 32'h0;
            12'h170: return m_dv0[d];
            12'h174: return m_dv1[d];
            12'hC00: return m_sd0[d];
            12'hC04: return m_sd1[d];
            12'hC10: return m_stl[d];
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        cyc++;
        for (int d = 0; d < ND; d++) begin
            if (rst) begin
                m_req[d] = 0; m_dv0[d] = 0; m_dv1[d] = 0; m_sd0[d] = 0;
                m_sd1[d] = 0; m_stl[d] = 0; m_on[d] = 0; m_ph[d] = 0;
                m_t[d] = 0; m_end[d] = 0;
            end else begin
                if (m_ph[d] == 0) begin
                    if (!m_on[d] && m_req[d][3:0] == 4'h8) begin
                        m_ph[d] = 1; m_t[d] = 0;
                        m_end[d] = rise_at(d, NS) + int'(m_stl[d][7:0]) + 1;
                    end else if (m_on[d] && m_req[d][3:0] == 4'h0) begin
                        m_ph[d] = 2; m_t[d] = 0; m_end[d] = NS;
                    end
                end else begin
                    m_t[d]++;
                    if (m_t[d] == m_end[d]) begin
                        m_on[d] = (m_ph[d] == 1);
                        m_ph[d] = 0;
                    end
                end
                if (bus_wr && int'(bus_addr[14:12]) == d) begin
                    case (bus_addr[11:0])
                        12'h000: m_req[d] = bus_wdata;
                        12'h170: m_dv0[d] = bus_wdata;
                        12'h174: m_dv1[d] = bus_wdata;
                        12'hC00: m_sd0[d] = bus_wdata;
                        12'hC04: m_sd1[d] = bus_wdata;
                        12'hC10: m_stl[d] = bus_wdata;
                        default: ;
                    endcase
                end
            end
        end
    end

    // per-cycle comparison of outputs
    always @(negedge clk) begin
        if (!rst && !done) begin
            for (int d = 0; d < ND; d++) begin
                tests++;
                if (sw_en[d*NS +: NS] !== exp_en(d)) begin
                    fails++;
                    $display("FAIL R5/R7 R1 dom %0d sw_en act=%b exp=%b cyc %0d",
                             d, sw_en[d*NS +: NS], exp_en(d), cyc);
                end
                tests++;
                if (pd_ready[d] !== (m_on[d] && m_ph[d] == 0)) begin
                    fails++;
                    $display("FAIL R6 dom %0d pd_ready act=%b exp=%b cyc %0d",
                             d, pd_ready[d], (m_on[d] && m_ph[d] == 0), cyc);
                end
            end
        end
    end

    task automatic wr(int d, logic [11:0] ofs, logic [31:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = {3'(d), ofs}; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(int d, logic [11:0] ofs, string tag);
        logic [31:0] e;
        @(negedge clk);
        bus_addr = {3'(d), ofs};
        #1;
        e = model_read(bus_addr);
        tests++;
        if (bus_rdata !== e) begin
            fails++;
            $display("FAIL %s dom %0d ofs %h act=%h exp=%h", tag, d, ofs, bus_rdata, e);
        end
    endtask

    task automatic rd_const(int d, logic [11:0] ofs, logic [31:0] e, string tag);
        @(negedge clk);
        bus_addr = {3'(d), ofs};
        #1;
        tests++;
        if (bus_rdata !== e) begin
            fails++;
            $display("FAIL %s dom %0d ofs %h act=%h exp=%h", tag, d, ofs, bus_rdata, e);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10: reset state
        rd_const(0, 12'h000, 32'h0, "R10");
        rd_const(7, 12'hC00, 32'h0, "R10");
        rd_const(7, 12'h008, 32'h0, "R10");
        tests++;
        if (sw_en !== '0 || pd_ready !== '0) begin
            fails++;
            $display("FAIL R10 outputs act=%h/%h exp=0/0", sw_en, pd_ready);
        end
        // R2: readback right after write, zero delays power-up
        wr(2, 12'h000, 32'hAB00_0008);
        rd_const(2, 12'h000, 32'hAB00_0008, "R2");
        rd_const(2, 12'h008, 32'h0, "R9 busy state");
        idle(12);
        rd_const(2, 12'h008, 32'h8, "R3 R6");
        rd_const(4, 12'h000, 32'h0, "R1");
        // R4: timing registers on domain 5
        wr(5, 12'h170, 32'h00FF_FFFF);
        wr(5, 12'h174, 32'h0000_FFFF);
        wr(5, 12'hC00, 32'h0302_0104);
        wr(5, 12'hC04, 32'h0000_0502);
        wr(5, 12'hC10, 32'h0000_0006);
        rd(5, 12'h170, "R4");
        rd(5, 12'h174, "R4");
        rd(5, 12'hC00, "R4");
        rd(5, 12'hC04, "R4");
        rd(5, 12'hC10, "R4");
        rd_const(4, 12'hC00, 32'h0, "R1");
        // R5 R6: staged power-up
        wr(5, 12'h000, 32'h8);
        idle(40);
        rd_const(5, 12'h008, 32'h8, "R6");
        // R7 R9: power-down with a re-request during the drop
        wr(5, 12'h000, 32'h0);
        wr(5, 12'h000, 32'h8);
        rd_const(5, 12'h000, 32'h8, "R9 readback");
        rd_const(5, 12'h008, 32'h8, "R9 mid-drop");
        idle(50);
        rd_const(5, 12'h008, 32'h8, "R9 resumed");
        wr(5, 12'h000, 32'h0);
        idle(10);
        rd_const(5, 12'h008, 32'h0, "R7");
        // R8: invalid mode codes
        wr(3, 12'h000, 32'h5);
        idle(15);
        rd_const(3, 12'h000, 32'h5, "R8");
        rd_const(3, 12'h008, 32'h0, "R8");
        wr(3, 12'h000, 32'h8);
        idle(15);
        wr(3, 12'h000, 32'h3);
        idle(15);
        rd_const(3, 12'h008, 32'h8, "R8");
        // R3: state is read-only
        wr(1, 12'h008, 32'h8);
        idle(12);
        rd_const(1, 12'h008, 32'h0, "R3");
        // R10: unmapped offsets
        wr(6, 12'h004, 32'hDEAD_BEEF);
        wr(6, 12'hC08, 32'h8);
        rd_const(6, 12'h004, 32'h0, "R10");
        rd_const(6, 12'hC08, 32'h0, "R10");
        rd_const(6, 12'h000, 32'h0, "R10");
        idle(5);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        wait (cyc >= 150000);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired act=hang exp=finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule